// File: doc/BRIEF.md
# Platform Reset Pulse Sequencer

This block generates the active-low reset that holds every downstream device on a platform in reset. Two power-good indications, one for core power and one for the voltage regulator, come in asynchronously and pass through synchronizers. The reset output is held asserted from power-up until both have been high for a programmable hold time. A one-cycle software strobe, raised when the reset-control register is written, produces a reset pulse of guaranteed minimum width. A further request while that pulse is still running extends it.

A dip in core power good always asserts the reset at once. A slow real-time clock decides how the dip is treated. A dip that spans a set number of rising edges of that clock counts as a genuine loss of power, and the block then requires the full hold time before it releases reset again. A shorter dip counts only as a glitch, and reset is released one minimum pulse width after core power good returns. A loss of regulator power good always forces the full power-up sequence. All timing is given in system-clock cycles, so simulation can use small values.

Top module: `plat_rst_seq`

## Requirements
- R1: While the block reset input `rst_n` is low, `plat_rst_n` is low (asynchronously). After it is released, `plat_rst_n` stays low for as long as either power-good input is low.
- R2: Both power-good inputs are first high after a time in the power-down state. `plat_rst_n` then rises exactly SYNC_STAGES+1+HOLD_CYCLES clock edges after the later of the two inputs went high, and never sooner.
- R3: `sw_rst_req` sampled high at a clock edge drives `plat_rst_n` low at that same edge. The output stays low for exactly PULSE_CYCLES edges and then rises again.
- R4: A new `sw_rst_req` while the software pulse is running restarts its width. `plat_rst_n` stays low continuously and rises PULSE_CYCLES edges after the last request.
- R5: `core_pg_async` falling while reset is released drives `plat_rst_n` low exactly SYNC_STAGES+1 edges later.
- R6: A core power-good dip that spans fewer than DROP_TICKS rising edges of `rtc_clk_async` is a glitch. `plat_rst_n` rises exactly SYNC_STAGES+1+PULSE_CYCLES edges after core power good returns.
- R7: A core power-good dip that spans DROP_TICKS or more slow-clock rising edges is a full power loss. On its return, release follows the R2 timing.
- R8: Either power-good input going low during the hold time cancels the hold. Release then follows the R2 timing, counted from the input's return.
- R9: `vr_pg_async` going low at any time asserts `plat_rst_n` after SYNC_STAGES+1 edges. On its return, release follows the R2 timing.
- R10: Every asynchronous input passes through SYNC_STAGES flip-flops before it is used. The parameters are checked when the design is elaborated: SYNC_STAGES >= 2, and HOLD_CYCLES, PULSE_CYCLES and DROP_TICKS all >= 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Block reset, active low, asynchronous assert |
| core_pg_async | input | 1 | Core power good, asynchronous, high = good |
| vr_pg_async | input | 1 | Regulator power good, asynchronous, high = good |
| rtc_clk_async | input | 1 | Slow real-time clock, used to qualify dips |
| sw_rst_req | input | 1 | One-cycle software hard-reset strobe, synchronous to clk |
| plat_rst_n | output | 1 | Platform reset, active low, registered |

## Verification
On every cycle, the embedded assertions check several things. A release only happens after both synchronized power-good signals were high. A software strobe or a low power-good pulls the output low on the next edge. The hold state never releases the output, and a lost input during the hold falls back to the power-down state. They also check that a glitch recovery returns through the pulse timer, and that the pulse counter stays within its range. The bench scenarios are the only thing that shows the exact release latencies. They sweep dip lengths on both sides of the slow-clock qualification boundary and request spacings on both sides of the pulse width. Those results depend on multi-cycle counts and on the phase of the slow clock, which the single-step properties do not follow.

// File: rtl/prst_pkg.sv
package prst_pkg;
   typedef enum logic [1:0] {
      ST_OFF  = 2'd0,
      ST_HOLD = 2'd1,
      ST_RUN  = 2'd2,
      ST_DIP  = 2'd3
   } seq_state_e;
endpackage

// File: rtl/prst_sync.sv
module prst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("prst_sync: STAGES must be at least 2 (R10)");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/prst_dropq.sv
module prst_dropq #(
   parameter int SYNC_STAGES = 2,
   parameter int DROP_TICKS  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rtc_async,
   input  logic arm,
   output logic qual
);
   logic rtc_s, rtc_d, tick;

   prst_sync #(.STAGES(SYNC_STAGES)) u_rtc_sync (
      .clk(clk), .rst_n(rst_n), .d(rtc_async), .q(rtc_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rtc_d <= 1'b0;
      else        rtc_d <= rtc_s;
   end

   assign tick = rtc_s & ~rtc_d;

   generate
      if (DROP_TICKS < 1) begin : g_bad_drop
         $error("prst_dropq: DROP_TICKS must be at least 1 (R10)");
      end else if (DROP_TICKS == 1) begin : g_single
         assign qual = arm & tick;
      end else begin : g_count
         localparam int TW = $clog2(DROP_TICKS);
         localparam logic [TW-1:0] TLAST = TW'(DROP_TICKS - 1);
         logic [TW-1:0] tcnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         tcnt <= '0;
            else if (!arm)      tcnt <= '0;
            else if (tick && tcnt != TLAST) tcnt <= tcnt + 1'b1;
         end

         assign qual = arm & tick & (tcnt == TLAST);

         p_tick_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
            tcnt <= TLAST);
      end
   endgenerate
endmodule

// File: rtl/prst_stretch.sv
module prst_stretch #(
   parameter int PULSE_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic done_nx
);
   generate
      if (PULSE_CYCLES < 1) begin : g_bad_pulse
         $error("prst_stretch: PULSE_CYCLES must be at least 1 (R10)");
      end
   endgenerate

   localparam int PW = $clog2(PULSE_CYCLES + 1);
   localparam logic [PW-1:0] PFULL = PW'(PULSE_CYCLES);

   logic [PW-1:0] pcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pcnt <= '0;
      else if (load)           pcnt <= PFULL;
      else if (pcnt != '0)     pcnt <= pcnt - 1'b1;
   end

   assign done_nx = !load && (pcnt <= PW'(1));

   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt <= PFULL);
   p_load_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (pcnt == PFULL));
endmodule

// File: rtl/plat_rst_seq.sv
module plat_rst_seq
   import prst_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int HOLD_CYCLES  = 200000,
   parameter int PULSE_CYCLES = 200000,
   parameter int DROP_TICKS   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic core_pg_async,
   input  logic vr_pg_async,
   input  logic rtc_clk_async,
   input  logic sw_rst_req,
   output logic plat_rst_n
);
   generate
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("plat_rst_seq: HOLD_CYCLES must be at least 1 (R10)");
      end
   endgenerate

   localparam int HW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
   localparam logic [HW-1:0] HLAST = HW'(HOLD_CYCLES - 1);

   logic core_s, vr_s, both_s, qual, load, done_nx, release_nx;
   seq_state_e    st, st_nx;
   logic [HW-1:0] hcnt, hcnt_nx;

   prst_sync #(.STAGES(SYNC_STAGES)) u_core_sync (
      .clk(clk), .rst_n(rst_n), .d(core_pg_async), .q(core_s)
   );
   prst_sync #(.STAGES(SYNC_STAGES)) u_vr_sync (
      .clk(clk), .rst_n(rst_n), .d(vr_pg_async), .q(vr_s)
   );

   assign both_s = core_s & vr_s;

   prst_dropq #(.SYNC_STAGES(SYNC_STAGES), .DROP_TICKS(DROP_TICKS)) u_dropq (
      .clk(clk), .rst_n(rst_n), .rtc_async(rtc_clk_async),
      .arm(st == ST_DIP), .qual(qual)
   );

   assign load = sw_rst_req | ((st == ST_DIP) & both_s);

   prst_stretch #(.PULSE_CYCLES(PULSE_CYCLES)) u_stretch (
      .clk(clk), .rst_n(rst_n), .load(load), .done_nx(done_nx)
   );

   always_comb begin
      st_nx   = st;
      hcnt_nx = hcnt;
      unique case (st)
         ST_OFF: begin
            hcnt_nx = '0;
            if (both_s) st_nx = ST_HOLD;
         end
         ST_HOLD: begin
            if (!both_s) begin
               st_nx   = ST_OFF;
               hcnt_nx = '0;
            end else if (hcnt == HLAST) begin
               st_nx   = ST_RUN;
               hcnt_nx = '0;
            end else begin
               hcnt_nx = hcnt + 1'b1;
            end
         end
         ST_RUN: begin
            if (!vr_s)        st_nx = ST_OFF;
            else if (!core_s) st_nx = ST_DIP;
         end
         ST_DIP: begin
            if (!vr_s)        st_nx = ST_OFF;
            else if (core_s)  st_nx = ST_RUN;
            else if (qual)    st_nx = ST_OFF;
         end
         default: st_nx = ST_OFF;
      endcase
   end

   assign release_nx = (st_nx == ST_RUN) & done_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_OFF;
         hcnt       <= '0;
         plat_rst_n <= 1'b0;
      end else begin
         st         <= st_nx;
         hcnt       <= hcnt_nx;
         plat_rst_n <= release_nx;
      end
   end

   p_release_pg_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(plat_rst_n) |-> $past(both_s));
   p_hold_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HOLD) |-> !plat_rst_n);
   p_sw_assert_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst_req |=> !plat_rst_n);
   p_core_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !core_s |=> !plat_rst_n);
   p_short_recover_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DIP && both_s) |=> (st == ST_RUN && !plat_rst_n));
   p_hold_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HOLD && !both_s) |=> (st == ST_OFF));
   p_vr_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !vr_s |=> (st == ST_OFF && !plat_rst_n));
endmodule

// File: tb/plat_rst_seq_tb_top.sv
module plat_rst_seq_tb_top;
   localparam int SYNC  = 2;
   localparam int HOLD  = 64;
   localparam int PULSE = 16;
   localparam int DROP  = 3;
   localparam int RTC_HALF = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic core_pg = 1'b0, vr_pg = 1'b0, rtc = 1'b0, sw_req = 1'b0;
   logic plat_rst_n;

   int n_vec = 0, n_bad = 0, rtc_cnt = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   always @(negedge clk) begin
      if (rtc_cnt == RTC_HALF - 1) begin
         rtc_cnt <= 0;
         rtc     <= ~rtc;
      end else begin
         rtc_cnt <= rtc_cnt + 1;
      end
   end

   plat_rst_seq #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD),
                  .PULSE_CYCLES(PULSE), .DROP_TICKS(DROP)) dut_i (
      .clk(clk), .rst_n(rst_n), .core_pg_async(core_pg), .vr_pg_async(vr_pg),
      .rtc_clk_async(rtc), .sw_rst_req(sw_req), .plat_rst_n(plat_rst_n)
   );

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input logic exp, input string req);
      n_vec++;
      if (plat_rst_n !== exp) begin
         n_bad++;
         $display("FAIL %s: plat_rst_n=%b expected %b at %0t", req, plat_rst_n, exp, $time);
      end
   endtask

   task automatic sw_pulse;
      sw_req = 1'b1;
      cyc(1);
      sw_req = 1'b0;
   endtask

   // After an input change made at a negedge, release comes SYNC+1+delay edges later.
   task automatic expect_release(input int delay, input string req);
      cyc(SYNC + delay);
      chk(1'b0, req);
      cyc(1);
      chk(1'b1, req);
   endtask

   initial begin
      cyc(4);
      chk(1'b0, "R1 block reset");
      rst_n = 1'b1;
      cyc(20);
      chk(1'b0, "R1 both power-good low");
      vr_pg = 1'b1;
      cyc(HOLD + 20);
      chk(1'b0, "R1 core power-good still low");
      core_pg = 1'b1;
      expect_release(HOLD, "R2 power-up release");

      // R3: single software pulse
      sw_pulse();
      chk(1'b0, "R3 pulse start");
      cyc(PULSE - 1);
      chk(1'b0, "R3 pulse width");
      cyc(1);
      chk(1'b1, "R3 pulse end");

      // R4: second request at offset j after the first
      for (int j = 1; j <= PULSE + 3; j++) begin
         bit gap_ok = 1;
         sw_pulse();
         for (int k = 1; k < j; k++) begin
            if (j <= PULSE && plat_rst_n !== 1'b0) gap_ok = 0;
            cyc(1);
         end
         if (j <= PULSE && plat_rst_n !== 1'b0) gap_ok = 0;
         n_vec++;
         if (!gap_ok) begin
            n_bad++;
            $display("FAIL R4 extension gap j=%0d: plat_rst_n=1 expected 0", j);
         end
         sw_pulse();
         chk(1'b0, "R4 second request");
         cyc(PULSE - 1);
         chk(1'b0, "R4 extended width");
         cyc(1);
         chk(1'b1, "R4 release after last request");
      end

      // R5/R6: short core dips (at most two slow-clock edges)
      for (int len = SYNC + 1; len <= 38; len++) begin
         core_pg = 1'b0;
         cyc(SYNC);
         chk(1'b1, "R5 before sync latency");
         cyc(1);
         chk(1'b0, "R5 core drop asserts");
         cyc(len - SYNC - 1);
         core_pg = 1'b1;
         expect_release(PULSE, "R6 glitch recovery");
      end

      // R7: long core dips
      for (int len = 70; len <= 130; len += 20) begin
         core_pg = 1'b0;
         cyc(len);
         core_pg = 1'b1;
         cyc(SYNC + PULSE + 1);
         chk(1'b0, "R7 not treated as glitch");
         cyc(HOLD - PULSE - 1);
         chk(1'b0, "R7 full hold");
         cyc(1);
         chk(1'b1, "R7 release");
      end

      // R8: regulator drop during the hold
      vr_pg = 1'b0;
      cyc(10);
      vr_pg = 1'b1;
      cyc(HOLD / 2);
      vr_pg = 1'b0;
      cyc(6);
      vr_pg = 1'b1;
      expect_release(HOLD, "R8 hold restart on regulator drop");

      // R8: core drop during the hold
      vr_pg = 1'b0;
      cyc(10);
      vr_pg = 1'b1;
      cyc(HOLD / 2);
      core_pg = 1'b0;
      cyc(6);
      core_pg = 1'b1;
      expect_release(HOLD, "R8 hold restart on core drop");

      // R9: short regulator drop from the running state forces full sequence
      vr_pg = 1'b0;
      cyc(SYNC);
      chk(1'b1, "R9 before sync latency");
      cyc(1);
      chk(1'b0, "R9 regulator drop asserts");
      cyc(3);
      vr_pg = 1'b1;
      expect_release(HOLD, "R9 full hold after regulator drop");

      // R10/R1: block reset mid-run asserts immediately, then full sequence
      rst_n = 1'b0;
      #1;
      chk(1'b0, "R1 async block reset");
      cyc(3);
      rst_n = 1'b1;
      expect_release(HOLD, "R10 sync chain after block reset");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule